// File: doc/BRIEF.md
# Oversampled Serial Frame Decoder

This block recovers the bytes of a serial frame from a line that is sent by a node with its own clock. Each line bit lasts eight receiver clock cycles. The receiver first passes the raw line through a two-register synchronizer. It then forms a majority vote over the five most recent synchronized samples. A three-bit phase counter chooses one voted sample per bit period and feeds it to a small state machine. That machine walks through the frame structure: a low start bit, a high open bit, then for each byte a high/low separator pair followed by eight data bits, and finally a low/high tail.

The phase counter has no clock recovery beyond re-alignment. It is pinned while the idle line is high. It is reloaded on the high-to-low edge inside every byte separator, so the bit phase is refreshed once per byte. Drift between sender and receiver therefore only builds up over ten bit periods. Decoded bytes appear with a one-cycle valid pulse, a completed frame gives a one-cycle done pulse, and any bit that breaks the frame structure gives a one-cycle error pulse and returns the machine to idle.

Top module: `serial_frame_decoder`

## Requirements
- R1: While reset is asserted and after its release, `byte_valid`, `frame_done` and `frame_err` are low until a frame is received.
- R2: The line passes two synchronizing registers and a five-sample majority vote, so a disturbance covering at most two receiver samples inside a data bit does not change the decoded byte.
- R3: A frame is a low start bit, a high open bit, then per byte a high bit, a low bit and eight data bits sent most significant bit first, then a low bit and a high bit. Each byte is output on `byte_data` in the order sent.
- R4: `byte_valid` is a single-cycle pulse, raised once per byte when the bit after the eighth data bit is taken.
- R5: `frame_done` is a single-cycle pulse, raised once when the final high bit of the tail is taken, and it is never raised together with `frame_err`.
- R6: A low bit where the open bit (high) is expected raises `frame_err` for one cycle, yields no bytes and no done pulse, and the next correct frame decodes fully.
- R7: A high bit where the low half of a byte separator is expected raises `frame_err` once, with no done pulse. The bytes completed before it are still output.
- R8: Frames of 60 bytes decode without error when the sender bit period is 0.15% longer or shorter than eight receiver cycles.
- R9: A line held high produces no output pulses.
- R10: The phase counter loads 1 on a high-to-low voted edge while idle or while waiting for the separator's low half. It takes a bit when it reaches 4, and it never takes one within three cycles of a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | receiver clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rx_line | input | 1 | asynchronous serial line, idle high |
| byte_data | output | 8 | last decoded byte |
| byte_valid | output | 1 | one-cycle pulse, `byte_data` is new |
| frame_done | output | 1 | one-cycle pulse, frame tail accepted |
| frame_err | output | 1 | one-cycle pulse, frame structure violated |

## Verification
The bench sweeps all 256 byte values through nominal-rate frames and sends constant-zero and constant-one payloads. All-zero data keeps the line low between separators, and all-one data leaves only the separator edge to resynchronize on. Long frames are repeated with the sender period stretched and shrunk by 0.15%. These runs show whether the per-byte realignment stops phase error from building up. Short glitches inside data bits separate a working majority vote from a single-sample path. A bad open bit and a missing separator edge test both error exits, and a clean frame after the first shows that the machine recovers.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LEAD    = 3'd1,
    ST_OPEN    = 3'd2,
    ST_SEP_HI  = 3'd3,
    ST_SEP_LO  = 3'd4,
    ST_DATA    = 3'd5,
    ST_TAIL_LO = 3'd6
  } rx_state_t;

  // next phase of a counter that wraps at modulus m
  function automatic int unsigned phase_next(input int unsigned c, input int unsigned m);
    return (c + 1 >= m) ? 0 : c + 1;
  endfunction

  // smallest number of ones that wins a vote over len samples
  function automatic int unsigned vote_threshold(input int unsigned len);
    return len / 2 + 1;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[0] <= 1'b1;
        else        q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b1;
        else        q[g] <= q[g-1];
      end
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote
  import rx_frame_pkg::*;
#(
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic voted
);
  localparam int CW  = $clog2(LEN + 1);
  localparam int THR = int'(vote_threshold(LEN));

  logic [LEN-1:0] win;
  logic [CW-1:0]  ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '1;
    else        win <= {win[LEN-2:0], din};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < LEN; i++) ones = ones + CW'(win[i]);
  end

  assign voted = (ones >= CW'(THR));
endmodule

// File: rtl/rx_bit_clock.sv
module rx_bit_clock
  import rx_frame_pkg::*;
#(
  parameter int OS_RATE   = 8,
  parameter int STROBE_AT = 4,
  parameter int LOAD_VAL  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_ev,
  output logic strobe
);
  localparam int CNT_W = $clog2(OS_RATE);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (sync_ev) cnt <= CNT_W'(LOAD_VAL);
    else              cnt <= CNT_W'(phase_next(32'(cnt), OS_RATE));
  end

  assign strobe = (cnt == CNT_W'(STROBE_AT));
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_frame_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              bit_in,
  output rx_state_t         st,
  output logic [DATA_W-1:0] byte_q,
  output logic              byte_pulse,
  output logic              done_pulse,
  output logic              err_pulse
);
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam logic [NB_W-1:0] FULL = NB_W'(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [NB_W-1:0]   nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      shreg      <= '0;
      nbits      <= '0;
      byte_q     <= '0;
      byte_pulse <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      byte_pulse <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      if (strobe) begin
        unique case (st)
          ST_IDLE: if (!bit_in) st <= ST_LEAD;
          ST_LEAD: begin
            if (bit_in) st <= ST_OPEN;
            else begin err_pulse <= 1'b1; st <= ST_IDLE; end
          end
          ST_OPEN: begin
            if (bit_in) st <= ST_SEP_HI;
            else begin err_pulse <= 1'b1; st <= ST_IDLE; end
          end
          ST_SEP_HI: begin
            if (!bit_in) st <= ST_SEP_LO;
            else begin err_pulse <= 1'b1; st <= ST_IDLE; end
          end
          ST_SEP_LO: begin
            shreg <= {shreg[DATA_W-2:0], bit_in};
            nbits <= NB_W'(1);
            st    <= ST_DATA;
          end
          ST_DATA: begin
            if (nbits == FULL) begin
              byte_q     <= shreg;
              byte_pulse <= 1'b1;
              st         <= bit_in ? ST_SEP_HI : ST_TAIL_LO;
            end else begin
              shreg <= {shreg[DATA_W-2:0], bit_in};
              nbits <= nbits + NB_W'(1);
            end
          end
          ST_TAIL_LO: begin
            if (bit_in) done_pulse <= 1'b1;
            else        err_pulse  <= 1'b1;
            st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_decoder.sv
module serial_frame_decoder
  import rx_frame_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 8,
  parameter int STROBE_AT   = 4,
  parameter int VOTE_LEN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              frame_done,
  output logic              frame_err
);
  logic      line_s;
  logic      voted;
  logic      voted_d;
  logic      sync_ev;
  logic      strobe;
  rx_state_t st;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rx_vote #(.LEN(VOTE_LEN)) u_vote (
    .clk(clk), .rst_n(rst_n), .din(line_s), .voted(voted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) voted_d <= 1'b1;
    else        voted_d <= voted;
  end

  // realign on idle-high and on the falling edge inside a byte separator
  assign sync_ev = ((st == ST_IDLE) && voted_d) ||
                   ((st == ST_SEP_HI) && voted_d && !voted);

  rx_bit_clock #(.OS_RATE(OS_RATE), .STROBE_AT(STROBE_AT), .LOAD_VAL(1)) u_clk (
    .clk(clk), .rst_n(rst_n), .sync_ev(sync_ev), .strobe(strobe)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .bit_in(voted), .st(st),
    .byte_q(byte_data), .byte_pulse(byte_valid),
    .done_pulse(frame_done), .err_pulse(frame_err)
  );
endmodule

// File: rtl/serial_frame_decoder_chk.sv
module serial_frame_decoder_chk
  import rx_frame_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      strobe,
  input logic      sync_ev,
  input rx_state_t st,
  input logic      byte_valid,
  input logic      frame_done,
  input logic      frame_err
);
  // R4
  byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R5
  done_from_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(st) == ST_TAIL_LO);

  // R5
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame_err);

  // R6
  err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> st == ST_IDLE);

  // R3
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(st));

  // R10
  strobe_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !$past(sync_ev, 1) && !$past(sync_ev, 2) && !$past(sync_ev, 3));
endmodule

bind serial_frame_decoder serial_frame_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .sync_ev(sync_ev), .st(st),
  .byte_valid(byte_valid), .frame_done(frame_done), .frame_err(frame_err)
);

// File: tb/test_serial_frame_decoder.sv
`timescale 1ns/1ps
module test_serial_frame_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] byte_data;
  logic       byte_valid, frame_done, frame_err;

  serial_frame_decoder i_serial_frame_decoder (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .byte_data(byte_data),
    .byte_valid(byte_valid), .frame_done(frame_done), .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit ended = 0;
  logic [7:0] tx [0:255];
  logic [7:0] got [0:255];
  int got_n = 0, done_n = 0, err_n = 0, bv_dbl = 0, dn_dbl = 0;
  logic bv_prev = 0, dn_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (got_n < 256) got[got_n] = byte_data;
        got_n++;
      end
      if (frame_done) done_n++;
      if (frame_err) err_n++;
      if (byte_valid && bv_prev) bv_dbl++;
      if (frame_done && dn_prev) dn_dbl++;
    end
    bv_prev = byte_valid;
    dn_prev = frame_done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input real per, input bit glitch);
    if (glitch) begin
      rx_line = b;  #(3.5 * per);
      rx_line = ~b; #(per);
      rx_line = b;  #(3.5 * per);
    end else begin
      rx_line = b;  #(8.0 * per);
    end
  endtask

  // mode 0 clean, 1 bad open bit, 2 missing separator low half, 3 glitches in data
  task automatic send_frame(input int n, input real per, input int mode);
    send_bit(1'b0, per, 0);
    send_bit(mode == 1 ? 1'b0 : 1'b1, per, 0);
    if (mode != 1) begin
      for (int i = 0; i < n; i++) begin
        send_bit(1'b1, per, 0);
        send_bit(1'b0, per, 0);
        for (int k = 7; k >= 0; k--)
          send_bit(tx[i][k], per, (mode == 3) && (k == 2 || k == 5));
      end
      if (mode == 2) begin
        send_bit(1'b1, per, 0);
        send_bit(1'b1, per, 0);
      end else begin
        send_bit(1'b0, per, 0);
        send_bit(1'b1, per, 0);
      end
    end
    rx_line = 1'b1;
    #(8.0 * per * 6);
  endtask

  task automatic run_frame(input int n, input real per, input int mode, input string req);
    int exp_n, exp_done, exp_err, mism;
    got_n = 0; done_n = 0; err_n = 0;
    @(negedge clk);
    send_frame(n, per, mode);
    exp_n    = (mode == 1) ? 0 : n;
    exp_done = (mode == 0 || mode == 3) ? 1 : 0;
    exp_err  = (mode == 1 || mode == 2) ? 1 : 0;
    chk(got_n == exp_n, {req, " byte count"}, got_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got[i] !== tx[i]) begin
        if (mism == 0)
          $display("FAIL %s byte %0d actual=%0d expected=%0d", req, i, got[i], tx[i]);
        mism++;
      end
    total++;
    if (mism != 0) bad++;
    chk(done_n == exp_done, {req, " done pulses"}, done_n, exp_done);
    chk(err_n == exp_err, {req, " error pulses"}, err_n, exp_err);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5.0);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!byte_valid && !frame_done && !frame_err, "R1 reset", byte_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!byte_valid && !frame_done && !frame_err, "R1 after release", frame_err, 0);

    // R9: idle high line
    got_n = 0; done_n = 0; err_n = 0;
    repeat (200) @(negedge clk);
    chk(got_n + done_n + err_n == 0, "R9 idle", got_n + done_n + err_n, 0);

    // R3: nominal frame
    for (int i = 0; i < 60; i++) tx[i] = 8'(i * 7 + 3);
    run_frame(60, 5.0, 0, "R3 nominal");

    // R3: sweep of all byte values
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 64; i++) tx[i] = 8'(f * 64 + i);
      run_frame(64, 5.0, 0, "R3 sweep");
    end

    // R3: constant payloads
    for (int i = 0; i < 8; i++) tx[i] = 8'h00;
    run_frame(8, 5.0, 0, "R3 zeros");
    for (int i = 0; i < 8; i++) tx[i] = 8'hFF;
    run_frame(8, 5.0, 0, "R3 ones");

    // R8 R10: drift both ways
    for (int i = 0; i < 60; i++) tx[i] = 8'(i * 37) ^ 8'h5A;
    run_frame(60, 5.0075, 0, "R8 R10 slow sender");
    run_frame(60, 4.9925, 0, "R8 R10 fast sender");

    // R2: glitches inside data bits
    for (int i = 0; i < 16; i++) tx[i] = 8'hA5 ^ 8'(i);
    run_frame(16, 5.0, 3, "R2 glitch");

    // R6: bad open bit, then recovery
    run_frame(0, 5.0, 1, "R6 bad open");
    for (int i = 0; i < 4; i++) tx[i] = 8'(8'hC3 + i);
    run_frame(4, 5.0, 0, "R6 recovery");

    // R7: separator without low half
    for (int i = 0; i < 5; i++) tx[i] = 8'(8'h3C - i);
    run_frame(5, 5.0, 2, "R7 missing edge");

    // R4 R5: pulse widths over the whole run
    chk(bv_dbl == 0, "R4 byte_valid width", bv_dbl, 0);
    chk(dn_dbl == 0, "R5 frame_done width", dn_dbl, 0);

    finish_run();
  end
endmodule